// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is an 8-bit arithmetic and logic unit whose result is combinational and whose six status flags sit in a register. Each cycle the caller presents two operands and an operation code. The result comes back in the same cycle. The operation reads the stored carry and zero flags where it needs them. When `exec` is high, the flags that the operation defines are written at the next rising clock edge. All other flags keep their stored value.

The flags are carry, zero, negative, overflow, sign and half-carry. The sign flag is always the exclusive OR of negative and overflow, so it gives the true signed ordering after a compare. Carry acts as a borrow on subtraction. Increment and decrement leave carry alone, so a loop counter can run inside a multi-byte add or subtract chain. The chained subtract and compare only ever clear the zero flag. This lets a wide compare be built from byte compares.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register `flags` is all zero. Its bit layout is bit5 H (half-carry), bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C.
- R2: The status register changes only at a rising edge where `exec` is high. With `exec` low it holds its value, whatever the operation.
- R3: Add (op 0) gives a+b and add-with-carry (op 1) gives a+b+C. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on signed overflow.
- R4: Subtract (op 2) and compare (op 4) give a-b. Subtract-with-borrow (op 3) and compare-with-borrow (op 5) give a-b-C. C is set when b plus the incoming borrow exceeds a as unsigned values, H is the borrow into bit 4 from the low nibble, and V is set on signed overflow. Compares put the difference on `result` as well.
- R5: For op 3 and op 5, Z is cleared when the result is nonzero and otherwise keeps its previous value.
- R6: Increment (op 6) and decrement (op 7) give a+1 and a-1. They update V, N, Z and S and leave C and H unchanged. V is set exactly when increment gives 0x80 or decrement gives 0x7F.
- R7: AND (op 8), OR (op 9) and XOR (op 10) clear V, update N, Z and S, and leave C and H unchanged.
- R8: Complement (op 11) gives ~a and sets C, clears V, and keeps H. Negate (op 12) gives 0-a with flags as for a subtraction from zero: C is set when a is nonzero, and V is set when a is 0x80.
- R9: Logical shift right (op 14) shifts in 0, rotate right (op 15) shifts in the stored C, and arithmetic shift right (op 16) repeats bit 7. For all three, C takes the old bit 0, V becomes N XOR C, and H is unchanged.
- R10: Nibble swap (op 13) exchanges the two halves of a and changes no flag. Codes 17 to 31 pass a to `result` and change no flag.
- R11: For every flag-updating operation, Z is set when the result is zero (except as in R5), N equals result bit 7, and S always equals N XOR V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Write the operation's flags at the next edge |
| op | input | 5 | Operation code |
| a | input | 8 | First operand (minuend, shifted value) |
| b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| flags | output | 6 | Stored status flags {H,S,V,N,Z,C} |

## Verification
The assertions assume that `exec`, `op` and `result` are known, not X, at every rising edge after reset is released. They compare the stored flags with the code and result sampled one edge earlier. The bench meets this assumption by driving every input to a defined value during reset. From then on it changes inputs only at falling edges and keeps `exec` low whenever it is not applying an operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CPC  = 5'd5,
        OP_INC  = 5'd6,
        OP_DEC  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_COM  = 5'd11,
        OP_NEG  = 5'd12,
        OP_SWAP = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ASR  = 5'd16
    } op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } state_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int HALF = 4;

    logic [W:0]    wide;
    logic [HALF:0] low;

    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            low  = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            low  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
        sum = wide[W-1:0];
        co  = wide[W];
        hc  = low[HALF];
        if (sub)
            ov = (x[W-1] & ~y[W-1] & ~sum[W-1]) | (~x[W-1] & y[W-1] & sum[W-1]);
        else
            ov = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         shout
);
    localparam int H = W / 2;

    always_comb begin
        shout = a[0];
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_SWAP: res = {a[H-1:0], a[W-1:H]};
            OP_LSR:  res = {1'b0, a[W-1:1]};
            OP_ROR:  res = {cin, a[W-1:1]};
            OP_ASR:  res = {a[W-1], a[W-1:1]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic [5:0]        flags
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    state_t state_d, state_q;
    op_e    opc;
    flags_t cur, nf;

    logic [DATA_W-1:0] ax, ay, sum, bit_res;
    logic              acin, asub, co, hc, ov, shout, use_arith, zr;

    assign opc = op_e'(op);
    assign cur = state_q.flags;

    alu8_addsub #(.W(DATA_W)) i_addsub (
        .x(ax), .y(ay), .cin(acin), .sub(asub),
        .sum(sum), .co(co), .hc(hc), .ov(ov)
    );

    alu8_bitops #(.W(DATA_W)) i_bitops (
        .op(opc), .a(a), .b(b), .cin(cur.c),
        .res(bit_res), .shout(shout)
    );

    always_comb begin
        ax = a;
        ay = b;
        acin = 1'b0;
        asub = 1'b0;
        use_arith = 1'b1;
        case (opc)
            OP_ADD:               ;
            OP_ADC:               acin = cur.c;
            OP_SUB, OP_CMP:       asub = 1'b1;
            OP_SBC, OP_CPC:       begin asub = 1'b1; acin = cur.c; end
            OP_INC:               ay = ONE;
            OP_DEC:               begin ay = ONE; asub = 1'b1; end
            OP_NEG:               begin ax = '0; ay = a; asub = 1'b1; end
            default:              use_arith = 1'b0;
        endcase
        result = use_arith ? sum : bit_res;
    end

    always_comb begin
        zr = (result == '0);
        nf = cur;
        case (opc)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG: begin
                nf.c = co; nf.h = hc; nf.v = ov;
                nf.n = result[DATA_W-1]; nf.z = zr;
            end
            OP_SBC, OP_CPC: begin
                nf.c = co; nf.h = hc; nf.v = ov;
                nf.n = result[DATA_W-1]; nf.z = zr & cur.z;
            end
            OP_INC, OP_DEC: begin
                nf.v = ov; nf.n = result[DATA_W-1]; nf.z = zr;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nf.v = 1'b0; nf.n = result[DATA_W-1]; nf.z = zr;
            end
            OP_COM: begin
                nf.c = 1'b1; nf.v = 1'b0; nf.n = result[DATA_W-1]; nf.z = zr;
            end
            OP_LSR, OP_ROR, OP_ASR: begin
                nf.c = shout; nf.n = result[DATA_W-1]; nf.z = zr;
                nf.v = result[DATA_W-1] ^ shout;
            end
            default: ;
        endcase
        nf.s = nf.n ^ nf.v;
        state_d = state_q;
        if (exec)
            state_d.flags = nf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign flags = state_q.flags;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec,
    input logic [4:0] op,
    input logic [7:0] result,
    input logic [5:0] flags
);
    // flags layout: [5]=H [4]=S [3]=V [2]=N [1]=Z [0]=C

    a_r2_hold_without_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(flags));

    a_r11_sign_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_n)
        flags[4] == (flags[2] ^ flags[3]));

    a_r6_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == 5'd6 || op == 5'd7)) |=> (flags[0] == $past(flags[0]) && flags[5] == $past(flags[5])));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == 5'd8 || op == 5'd9 || op == 5'd10)) |=> !flags[3]);

    a_r5_zero_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == 5'd3 || op == 5'd5) && !flags[1]) |=> !flags[1]);

    a_r10_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == 5'd13 || op > 5'd16)) |=> $stable(flags));

    a_r11_n_mirrors_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op <= 5'd16 && op != 5'd13) |=> flags[2] == $past(result[7]));

    a_r3_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 5'd0) |=> flags[1] == ($past(result) == 8'h00));
endmodule

bind alu8_core alu8_core_chk i_alu8_core_chk (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op),
    .result(result), .flags(flags)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic [7:0] result;
    logic [5:0] flags;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] got_r;

    always #10 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .exec(exec), .op(op),
        .a(a), .b(b), .result(result), .flags(flags)
    );

    // {op, a, b, init, expected result, expected flags {H,S,V,N,Z,C}}
    // init 0 -> flags 000010, init 1 -> 100011, init 2 -> 110101
    localparam int NV = 28;
    localparam logic [36:0] VEC [NV] = '{
        {5'd0,  8'h3A, 8'h46, 2'd0, 8'h80, 6'b101100},
        {5'd1,  8'hFF, 8'h00, 2'd1, 8'h00, 6'b100011},
        {5'd2,  8'h10, 8'h20, 2'd0, 8'hF0, 6'b010101},
        {5'd2,  8'h80, 8'h01, 2'd0, 8'h7F, 6'b111000},
        {5'd3,  8'h05, 8'h05, 2'd1, 8'hFF, 6'b110101},
        {5'd5,  8'h05, 8'h04, 2'd1, 8'h00, 6'b000010},
        {5'd5,  8'h05, 8'h04, 2'd2, 8'h00, 6'b000000},
        {5'd4,  8'h40, 8'h40, 2'd1, 8'h00, 6'b000010},
        {5'd6,  8'h7F, 8'h00, 2'd1, 8'h80, 6'b101101},
        {5'd6,  8'hFF, 8'h00, 2'd1, 8'h00, 6'b100011},
        {5'd7,  8'h80, 8'h00, 2'd0, 8'h7F, 6'b011000},
        {5'd7,  8'h01, 8'h00, 2'd1, 8'h00, 6'b100011},
        {5'd8,  8'hF0, 8'h3C, 2'd1, 8'h30, 6'b100001},
        {5'd9,  8'h80, 8'h01, 2'd0, 8'h81, 6'b010100},
        {5'd10, 8'h5A, 8'h5A, 2'd1, 8'h00, 6'b100011},
        {5'd11, 8'h0F, 8'h00, 2'd0, 8'hF0, 6'b010101},
        {5'd12, 8'h01, 8'h00, 2'd0, 8'hFF, 6'b110101},
        {5'd12, 8'h80, 8'h00, 2'd0, 8'h80, 6'b001101},
        {5'd12, 8'h00, 8'h00, 2'd1, 8'h00, 6'b000010},
        {5'd13, 8'hA5, 8'h00, 2'd1, 8'h5A, 6'b100011},
        {5'd14, 8'h01, 8'h00, 2'd0, 8'h00, 6'b011011},
        {5'd14, 8'h80, 8'h00, 2'd1, 8'h40, 6'b100000},
        {5'd15, 8'h02, 8'h00, 2'd1, 8'h81, 6'b101100},
        {5'd15, 8'h01, 8'h00, 2'd0, 8'h00, 6'b011011},
        {5'd16, 8'h81, 8'h00, 2'd0, 8'hC0, 6'b010101},
        {5'd16, 8'h7E, 8'h00, 2'd1, 8'h3F, 6'b100000},
        {5'd31, 8'h12, 8'h34, 2'd1, 8'h12, 6'b100011},
        {5'd0,  8'h08, 8'h08, 2'd0, 8'h10, 6'b100000}
    };

    function automatic string req_of(input logic [4:0] code);
        case (code)
            5'd0, 5'd1:         return "R3";
            5'd2, 5'd3, 5'd4:   return "R4";
            5'd5:               return "R5";
            5'd6, 5'd7:         return "R6";
            5'd8, 5'd9, 5'd10:  return "R7";
            5'd11, 5'd12:       return "R8";
            5'd14, 5'd15, 5'd16: return "R9";
            default:            return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y, input logic en);
        @(negedge clk);
        op = o; a = x; b = y; exec = en;
        #2 got_r = result;
        @(posedge clk);
        #2;
        @(negedge clk);
        exec = 1'b0;
    endtask

    task automatic preload(input logic [1:0] k);
        case (k)
            2'd0: apply(5'd0, 8'h00, 8'h00, 1'b1);
            2'd1: apply(5'd0, 8'hFF, 8'h01, 1'b1);
            default: apply(5'd2, 8'h00, 8'h01, 1'b1);
        endcase
    endtask

    task automatic finish_run;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 check("R1", {2'b00, flags}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            preload(VEC[i][15:14]);
            apply(VEC[i][36:32], VEC[i][31:24], VEC[i][23:16], 1'b1);
            check(req_of(VEC[i][36:32]), got_r, VEC[i][13:6]);
            check(req_of(VEC[i][36:32]), {2'b00, flags}, {2'b00, VEC[i][5:0]});
            // R11: sign equals N xor V after every operation
            check("R11", {7'b0, flags[4]}, {7'b0, flags[2] ^ flags[3]});
        end

        // R2: with exec low, an operation leaves the status register alone
        preload(2'd0);
        apply(5'd0, 8'hFF, 8'h01, 1'b0);
        check("R2", got_r, 8'h00);
        check("R2", {2'b00, flags}, 8'h02);
        apply(5'd14, 8'h01, 8'h00, 1'b0);
        check("R2", {2'b00, flags}, 8'h02);

        // R6: increment through a carry chain keeps a set C
        preload(2'd1);
        apply(5'd6, 8'h10, 8'h00, 1'b1);
        check("R6", {2'b00, flags}, {2'b00, 6'b100001});
        apply(5'd1, 8'h01, 8'h01, 1'b1);
        check("R6", got_r, 8'h03);

        // R1: reset in mid-run clears the status register
        preload(2'd2);
        @(negedge clk);
        rst_n = 1'b0;
        #2 check("R1", {2'b00, flags}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end
endmodule